// File: doc/BRIEF.md
# Block-ack transmit window tracker

This block follows one aggregation stream of a transmit queue. It keeps a sliding window of up to 64 consecutive frame indexes, counted modulo 256. For each slot in the window it remembers whether the frame went out on the air and whether the receiver acknowledged it. A transmit engine asks the block for the next frame index. The block offers a frame that was sent and is still unacknowledged ahead of any new frame, so frames can complete out of order.

Block-ack reports arrive as a starting sequence number and a 64-bit bitmap. The bits that fall inside the issued window mark frames as acknowledged. Once the oldest frames form a contiguous acknowledged run, the window start moves past that run and the slots are freed. A room flag shows whether the programmed window size still allows a new frame. A frame limit caps how many grants are handed out between two acknowledgement reports.

Top module: `ba_window_tracker`

## Requirements
- R1: After reset the window start and the next new index are both 0, nothing is in flight, and the first grant is new index 0. A pulse on `init_i` loads both indexes with `init_idx_i`, clears every slot and clears the grant counter.
- R2: When a new frame is offered (`grant_valid_o`=1, `grant_retry_o`=0), `grant_idx_o` equals `next_idx_o`. A cycle with `req_i` high takes the offer, and `next_idx_o` then increments modulo 256.
- R3: A sent report (`sent_i`) marks its index as transmitted only when the index lies in the issued window, that is, when (index − start) mod 256 < in-flight count. Any other sent report has no effect.
- R4: The retransmission offer takes priority over a new frame. It is the lowest-offset slot that was sent, is not acknowledged, and was not taken as a retry since the last acknowledgement report. A retry is flagged with `grant_retry_o`=1 and is not offered again until the next report.
- R5: In an acknowledgement report, bitmap bit i acknowledges index (`ba_ssn_i` + i) mod 256. Bits whose index lies outside the issued window are ignored.
- R6: In the cycle after a report, the window start moves past every consecutive acknowledged slot beginning at the start, and stops at the first unacknowledged slot. `in_flight_o` always equals (next − start) mod 256.
- R7: `room_o` is 1 exactly when the in-flight count is below the effective window size. The effective size is the programmed size, except that a programmed 0 or a value above 64 counts as 64. While `room_o` is 0 no new frame is offered.
- R8: Grants taken since the last acknowledgement report are counted, saturating at 127. While the count is not below `cfg_frame_limit_i`, no grant of either kind is offered. An acknowledgement report resets the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Restart the window at `init_idx_i` |
| init_idx_i | input | 8 | Starting index for a restart |
| cfg_win_size_i | input | 7 | Programmed window size (0 or >64 means 64) |
| cfg_frame_limit_i | input | 7 | Grants allowed between acknowledgement reports |
| req_i | input | 1 | Take the current grant offer |
| grant_valid_o | output | 1 | A grant is offered |
| grant_idx_o | output | 8 | Index of the offered frame |
| grant_retry_o | output | 1 | Offered frame is a retransmission |
| sent_i | input | 1 | Frame transmitted report |
| sent_idx_i | input | 8 | Index of the transmitted frame |
| ba_valid_i | input | 1 | Acknowledgement report valid |
| ba_ssn_i | input | 8 | Starting sequence of the bitmap |
| ba_bitmap_i | input | 64 | Acknowledgement bitmap, bit i = ssn + i |
| win_start_o | output | 8 | Oldest unacknowledged index (window start) |
| next_idx_o | output | 8 | Next new index to issue |
| in_flight_o | output | 7 | Issued frames still in the window |
| room_o | output | 1 | Window size allows a new frame |

## Verification
The bench aims at the index wrap from 255 to 0. An adder of the wrong width would make the window appear enormous or empty there, and would offer index 256 or stall. It sends acknowledgement reports whose start lies behind the window or whose bits reach past the next index. A design that ignored the window test would retire frames it never issued, or mark future frames acknowledged before they were sent. Out-of-order reports check that the start halts at the first hole and then jumps over the whole run once the hole closes. Repeated requests after a retry check that the same frame is not handed out twice per report. Tight window and frame-limit settings, including a programmed size of 0, check that new grants stop and resume exactly at the boundary.

// File: rtl/bawin_pkg.sv
package bawin_pkg;

    // Kind of offer presented on the grant port
    typedef enum logic [1:0] {
        GRANT_NONE  = 2'd0,
        GRANT_RETRY = 2'd1,
        GRANT_NEW   = 2'd2
    } grant_kind_e;

endpackage

// File: rtl/bawin_rotate.sv
// Rotates a slot vector so that bit k of the result is slot (sh + k) mod W.
module bawin_rotate #(
    parameter int W  = 64,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    input  logic [SW-1:0] sh_i,
    output logic [W-1:0]  rot_o
);
    for (genvar k = 0; k < W; k++) begin : g_rot
        logic [SW-1:0] src;
        assign src      = sh_i + SW'(k);
        assign rot_o[k] = vec_i[src];
    end
endmodule

// File: rtl/bawin_first_one.sv
// Finds the lowest set bit of a vector.
module bawin_first_one #(
    parameter int W  = 64,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [PW-1:0] pos_o
);
    always_comb begin
        found_o = 1'b0;
        pos_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                pos_o   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/bawin_ack_map.sv
// Maps a block-ack bitmap onto slot positions, keeping only issued frames.
module bawin_ack_map #(
    parameter int SEQ_W = 8,
    parameter int WIN   = 64,
    parameter int SW    = $clog2(WIN)
) (
    input  logic [SEQ_W-1:0] ssn_i,
    input  logic [SEQ_W-1:0] start_i,
    input  logic [SEQ_W-1:0] span_i,
    input  logic [WIN-1:0]   bitmap_i,
    output logic [WIN-1:0]   set_o
);
    always_comb begin
        logic [SEQ_W-1:0] idx;
        logic [SEQ_W-1:0] off;
        set_o = '0;
        for (int i = 0; i < WIN; i++) begin
            idx = ssn_i + SEQ_W'(i);
            off = idx - start_i;
            if (bitmap_i[i] && (off < span_i)) begin
                set_o[idx[SW-1:0]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker
    import bawin_pkg::*;
#(
    parameter int SEQ_W = 8,
    parameter int WIN   = 64,
    parameter int CFG_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_i,
    input  logic [SEQ_W-1:0]         init_idx_i,
    input  logic [CFG_W-1:0]         cfg_win_size_i,
    input  logic [CFG_W-1:0]         cfg_frame_limit_i,
    input  logic                     req_i,
    output logic                     grant_valid_o,
    output logic [SEQ_W-1:0]         grant_idx_o,
    output logic                     grant_retry_o,
    input  logic                     sent_i,
    input  logic [SEQ_W-1:0]         sent_idx_i,
    input  logic                     ba_valid_i,
    input  logic [SEQ_W-1:0]         ba_ssn_i,
    input  logic [WIN-1:0]           ba_bitmap_i,
    output logic [SEQ_W-1:0]         win_start_o,
    output logic [SEQ_W-1:0]         next_idx_o,
    output logic [$clog2(WIN+1)-1:0] in_flight_o,
    output logic                     room_o
);
    localparam int SLOT_W = $clog2(WIN);
    localparam int CNT_W  = $clog2(WIN + 1);

    typedef struct packed {
        logic [SEQ_W-1:0] start;
        logic [SEQ_W-1:0] next;
        logic [WIN-1:0]   sent;
        logic [WIN-1:0]   acked;
        logic [WIN-1:0]   reiss;
        logic [CFG_W-1:0] aggr;
    } state_t;

    state_t q, d;

    // ---------------- window geometry ----------------
    logic [SEQ_W-1:0]  span;
    logic [SEQ_W-1:0]  win_eff;
    logic [SLOT_W-1:0] start_slot;
    logic [WIN-1:0]    wmask;

    assign span       = q.next - q.start;
    assign start_slot = q.start[SLOT_W-1:0];

    always_comb begin
        if (cfg_win_size_i == '0 || int'(cfg_win_size_i) > WIN) begin
            win_eff = SEQ_W'(WIN);
        end else begin
            win_eff = SEQ_W'(cfg_win_size_i);
        end
    end

    for (genvar k = 0; k < WIN; k++) begin : g_wmask
        assign wmask[k] = SEQ_W'(k) < span;
    end

    // ---------------- window-relative views ----------------
    logic [WIN-1:0] rot_sent, rot_acked, rot_reiss;

    bawin_rotate #(.W(WIN), .SW(SLOT_W)) u_rot_sent (
        .vec_i (q.sent), .sh_i (start_slot), .rot_o (rot_sent)
    );
    bawin_rotate #(.W(WIN), .SW(SLOT_W)) u_rot_acked (
        .vec_i (q.acked), .sh_i (start_slot), .rot_o (rot_acked)
    );
    bawin_rotate #(.W(WIN), .SW(SLOT_W)) u_rot_reiss (
        .vec_i (q.reiss), .sh_i (start_slot), .rot_o (rot_reiss)
    );

    // ---------------- retry pick ----------------
    logic [WIN-1:0]    retry_cand;
    logic              retry_found;
    logic [SLOT_W-1:0] retry_off;
    logic [SEQ_W-1:0]  retry_idx;

    assign retry_cand = rot_sent & ~rot_acked & ~rot_reiss & wmask;

    bawin_first_one #(.W(WIN), .PW(SLOT_W)) u_pick_retry (
        .vec_i (retry_cand), .found_o (retry_found), .pos_o (retry_off)
    );

    assign retry_idx = q.start + SEQ_W'(retry_off);

    // ---------------- retirement of the acknowledged head ----------------
    logic [WIN-1:0]    head_open;
    logic              gap_found;
    logic [SLOT_W-1:0] gap_off;
    logic [CNT_W-1:0]  run;
    logic [WIN-1:0]    retire_mask;

    assign head_open = ~(rot_acked & wmask);

    bawin_first_one #(.W(WIN), .PW(SLOT_W)) u_find_gap (
        .vec_i (head_open), .found_o (gap_found), .pos_o (gap_off)
    );

    assign run = gap_found ? CNT_W'(gap_off) : CNT_W'(WIN);

    for (genvar s = 0; s < WIN; s++) begin : g_retire
        logic [SLOT_W-1:0] off_s;
        assign off_s          = SLOT_W'(s) - start_slot;
        assign retire_mask[s] = CNT_W'(off_s) < run;
    end

    // ---------------- acknowledgement mapping ----------------
    logic [WIN-1:0] ack_set;

    bawin_ack_map #(.SEQ_W(SEQ_W), .WIN(WIN), .SW(SLOT_W)) u_ack_map (
        .ssn_i    (ba_ssn_i),
        .start_i  (q.start),
        .span_i   (span),
        .bitmap_i (ba_bitmap_i),
        .set_o    (ack_set)
    );

    // ---------------- offer selection ----------------
    grant_kind_e      kind;
    logic             limit_ok;
    logic             room;
    logic [SEQ_W-1:0] sent_off;
    logic             sent_hit;
    logic             take;

    assign limit_ok = q.aggr < cfg_frame_limit_i;
    assign room     = span < win_eff;

    always_comb begin
        if (retry_found && limit_ok) begin
            kind = GRANT_RETRY;
        end else if (room && limit_ok) begin
            kind = GRANT_NEW;
        end else begin
            kind = GRANT_NONE;
        end
    end

    assign sent_off = sent_idx_i - q.start;
    assign sent_hit = sent_i && (sent_off < span);
    assign take     = req_i && (kind != GRANT_NONE);

    // ---------------- next state ----------------
    always_comb begin
        logic [CFG_W-1:0] aggr_base;
        d       = q;
        d.start = q.start + SEQ_W'(run);

        if (ba_valid_i) begin
            d.acked = q.acked | ack_set;
            d.reiss = '0;
        end

        if (sent_hit) begin
            d.sent[sent_idx_i[SLOT_W-1:0]] = 1'b1;
        end

        if (take && kind == GRANT_RETRY) begin
            d.reiss[retry_idx[SLOT_W-1:0]] = 1'b1;
        end
        if (take && kind == GRANT_NEW) begin
            d.next = q.next + 1'b1;
        end

        aggr_base = ba_valid_i ? '0 : q.aggr;
        if (take && aggr_base != {CFG_W{1'b1}}) begin
            d.aggr = aggr_base + 1'b1;
        end else begin
            d.aggr = aggr_base;
        end

        d.sent  = d.sent  & ~retire_mask;
        d.acked = d.acked & ~retire_mask;
        d.reiss = d.reiss & ~retire_mask;

        if (init_i) begin
            d       = '0;
            d.start = init_idx_i;
            d.next  = init_idx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // ---------------- outputs ----------------
    assign grant_valid_o = kind != GRANT_NONE;
    assign grant_retry_o = kind == GRANT_RETRY;
    assign grant_idx_o   = (kind == GRANT_RETRY) ? retry_idx : q.next;
    assign win_start_o   = q.start;
    assign next_idx_o    = q.next;
    assign in_flight_o   = CNT_W'(span);
    assign room_o        = room;

endmodule

// File: rtl/bawin_chk.sv
module bawin_chk #(
    parameter int SEQ_W = 8,
    parameter int WIN   = 64,
    parameter int CFG_W = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     init_i,
    input logic [SEQ_W-1:0]         init_idx_i,
    input logic [CFG_W-1:0]         cfg_win_size_i,
    input logic [CFG_W-1:0]         cfg_frame_limit_i,
    input logic                     req_i,
    input logic                     grant_valid_o,
    input logic [SEQ_W-1:0]         grant_idx_o,
    input logic                     grant_retry_o,
    input logic                     sent_i,
    input logic [SEQ_W-1:0]         sent_idx_i,
    input logic                     ba_valid_i,
    input logic [SEQ_W-1:0]         ba_ssn_i,
    input logic [WIN-1:0]           ba_bitmap_i,
    input logic [SEQ_W-1:0]         win_start_o,
    input logic [SEQ_W-1:0]         next_idx_o,
    input logic [$clog2(WIN+1)-1:0] in_flight_o,
    input logic                     room_o
);
    // R1: a restart loads both indexes
    p_init_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (win_start_o == $past(init_idx_i)) && (next_idx_o == $past(init_idx_i)));

    // R2: taking a new frame advances the next index by one
    p_new_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && grant_valid_o && !grant_retry_o && !init_i)
        |=> next_idx_o == SEQ_W'($past(next_idx_o) + 1'b1));

    // R4: a retry offer lies inside the issued window
    p_retry_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && grant_retry_o)
        |-> SEQ_W'(grant_idx_o - win_start_o) < SEQ_W'(in_flight_o));

    // R4: a retry taken is not offered again before the next report
    p_reissue_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && grant_valid_o && grant_retry_o && !ba_valid_i && !init_i)
        |=> !(grant_valid_o && grant_retry_o && grant_idx_o == $past(grant_idx_o)));

    // R6: the in-flight count never exceeds the window
    p_flight_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(in_flight_o) <= WIN);

    // R7: a new frame is offered only when there is room
    p_new_needs_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !grant_retry_o) |-> room_o);
endmodule

bind ba_window_tracker bawin_chk #(.SEQ_W(SEQ_W), .WIN(WIN), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/ba_window_tracker_test.sv
module ba_window_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_W = 8;
    localparam int WIN   = 64;
    localparam int CFG_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              init_i = 1'b0;
    logic [SEQ_W-1:0]  init_idx_i = '0;
    logic [CFG_W-1:0]  cfg_win_size_i = 7'd64;
    logic [CFG_W-1:0]  cfg_frame_limit_i = 7'd127;
    logic              req_i = 1'b0;
    logic              grant_valid_o;
    logic [SEQ_W-1:0]  grant_idx_o;
    logic              grant_retry_o;
    logic              sent_i = 1'b0;
    logic [SEQ_W-1:0]  sent_idx_i = '0;
    logic              ba_valid_i = 1'b0;
    logic [SEQ_W-1:0]  ba_ssn_i = '0;
    logic [WIN-1:0]    ba_bitmap_i = '0;
    logic [SEQ_W-1:0]  win_start_o;
    logic [SEQ_W-1:0]  next_idx_o;
    logic [6:0]        in_flight_o;
    logic              room_o;

    ba_window_tracker #(.SEQ_W(SEQ_W), .WIN(WIN), .CFG_W(CFG_W)) uut (
        .clk, .rst_n, .init_i, .init_idx_i, .cfg_win_size_i, .cfg_frame_limit_i,
        .req_i, .grant_valid_o, .grant_idx_o, .grant_retry_o, .sent_i, .sent_idx_i,
        .ba_valid_i, .ba_ssn_i, .ba_bitmap_i, .win_start_o, .next_idx_o,
        .in_flight_o, .room_o
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // ---------------- reference model ----------------
    int m_start, m_next, m_aggr, m_win, m_lim;
    bit m_sent[256];
    bit m_ack[256];
    bit m_re[256];

    function automatic int span_f();
        return (m_next - m_start) & 255;
    endfunction

    function automatic int weff_f();
        return (m_win == 0 || m_win > 64) ? 64 : m_win;
    endfunction

    function automatic bit in_win(int idx);
        return ((idx - m_start) & 255) < span_f();
    endfunction

    function automatic void exp_grant(output bit v, output int idx, output bit rt);
        bit lim_ok = m_aggr < m_lim;
        v = 0; idx = m_next; rt = 0;
        for (int o = 0; o < span_f(); o++) begin
            int s = (m_start + o) & 255;
            if (!rt && m_sent[s] && !m_ack[s] && !m_re[s]) begin
                rt = 1; idx = s;
            end
        end
        if (rt && lim_ok) v = 1;
        else begin
            rt = 0; idx = m_next;
            v = (span_f() < weff_f()) && lim_ok;
        end
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < 256; i++) begin
            m_sent[i] = 0; m_ack[i] = 0; m_re[i] = 0;
        end
    endfunction

    function automatic void model_retire();
        while (span_f() > 0 && m_ack[m_start]) begin
            m_sent[m_start] = 0; m_ack[m_start] = 0; m_re[m_start] = 0;
            m_start = (m_start + 1) & 255;
        end
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_status();
        bit v; int idx; bit rt;
        exp_grant(v, idx, rt);
        chk("R6", "win_start", int'(win_start_o), m_start);
        chk("R2", "next_idx", int'(next_idx_o), m_next);
        chk("R6", "in_flight", int'(in_flight_o), span_f());
        chk("R7", "room", int'(room_o), int'(span_f() < weff_f()));
        chk("R4 R7 R8", "grant_valid", int'(grant_valid_o), int'(v));
        if (v) begin
            chk("R4 R2", "grant_idx", int'(grant_idx_o), idx);
            chk("R4", "grant_retry", int'(grant_retry_o), int'(rt));
        end
    endtask

    // ---------------- stimulus tasks ----------------
    task automatic do_take();
        bit v; int idx; bit rt;
        exp_grant(v, idx, rt);
        req_i = 1;
        @(negedge clk);
        req_i = 0;
        if (v) begin
            if (rt) m_re[idx] = 1;
            else m_next = (m_next + 1) & 255;
            if (m_aggr < 127) m_aggr++;
        end
        model_retire();
        @(negedge clk);
        check_status();
    endtask

    task automatic do_sent(input int idx);
        sent_i = 1; sent_idx_i = SEQ_W'(idx);
        @(negedge clk);
        sent_i = 0;
        if (in_win(idx)) m_sent[idx] = 1;   // R3: outside the window has no effect
        model_retire();
        @(negedge clk);
        check_status();
    endtask

    task automatic do_ack(input int ssn, input logic [63:0] bm);
        ba_valid_i = 1; ba_ssn_i = SEQ_W'(ssn); ba_bitmap_i = bm;
        @(negedge clk);
        ba_valid_i = 0;
        for (int i = 0; i < 64; i++) begin
            int idx = (ssn + i) & 255;
            if (bm[i] && in_win(idx)) m_ack[idx] = 1;   // R5
        end
        for (int i = 0; i < 256; i++) m_re[i] = 0;
        m_aggr = 0;
        model_retire();
        @(negedge clk);
        check_status();
    endtask

    task automatic do_init(input int idx);
        init_i = 1; init_idx_i = SEQ_W'(idx);
        @(negedge clk);
        init_i = 0;
        model_clear();
        m_start = idx; m_next = idx; m_aggr = 0;
        @(negedge clk);
        check_status();
    endtask

    task automatic do_cfg(input int w, input int l);
        cfg_win_size_i = CFG_W'(w); cfg_frame_limit_i = CFG_W'(l);
        m_win = w; m_lim = l;
        @(negedge clk);
        check_status();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: got hang expected completion");
        summary();
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd4242));
        model_clear();
        m_start = 0; m_next = 0; m_aggr = 0; m_win = 64; m_lim = 127;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset start", int'(win_start_o), 0);
        chk("R1", "reset next", int'(next_idx_o), 0);
        chk("R1", "reset grant", int'(grant_valid_o), 1);
        check_status();

        // R2 wrap across 255 -> 0, R3 sent reports, R4/R6 out-of-order completion
        do_init(250);
        for (int i = 0; i < 8; i++) do_take();
        chk("R2", "next after wrap", int'(next_idx_o), 2);
        for (int i = 0; i < 8; i++) do_sent((250 + i) & 255);
        do_ack(250, 64'h0E);
        chk("R6", "start held at hole", int'(win_start_o), 250);
        chk("R4", "retry of hole", int'(grant_idx_o), 250);
        do_take();
        chk("R4", "next retry skips reissued", int'(grant_idx_o), 254);
        do_take();
        do_take();
        do_ack(250, 64'h01);
        chk("R6", "start jumps over run", int'(win_start_o), 254);

        // R5: bits beyond the issued window are ignored
        do_init(200);
        do_take(); do_take();
        do_sent(200); do_sent(201);
        do_ack(200, {64{1'b1}});
        chk("R5", "start after full ack", int'(win_start_o), 202);
        do_take();
        do_sent(202);
        chk("R5", "future bit ignored", int'(grant_retry_o), 1);
        do_sent(230);   // R3: outside window

        // R7: window full, then size 0 means 64
        do_init(10);
        do_cfg(4, 127);
        for (int i = 0; i < 5; i++) do_take();
        chk("R7", "room when full", int'(room_o), 0);
        chk("R7", "no grant when full", int'(grant_valid_o), 0);
        do_cfg(0, 127);
        chk("R7", "size zero gives room", int'(room_o), 1);

        // R8: frame limit
        do_init(100);
        do_cfg(64, 2);
        do_take(); do_take(); do_take();
        chk("R8", "blocked at limit", int'(grant_valid_o), 0);
        do_ack(100, 64'h0);
        chk("R8", "report reopens", int'(grant_valid_o), 1);
        do_cfg(64, 127);

        // constrained random mix
        for (int n = 0; n < 2500; n++) begin
            int r = $urandom % 100;
            if (r < 40) do_take();
            else if (r < 70) do_sent((m_start + int'($urandom % (span_f() + 4))) & 255);
            else if (r < 88) do_ack((m_start + int'($urandom % 8) + 253) & 255,
                                    {$urandom, $urandom} | {$urandom, $urandom});
            else if (r < 92) do_cfg(($urandom % 4 == 0) ? int'($urandom % 128) : 64,
                                    ($urandom % 4 == 0) ? int'($urandom % 8) : 127);
            else if (r < 93) do_init(int'($urandom % 256));
            else begin
                @(negedge clk);
                check_status();
            end
        end

        summary();
        $finish;
    end
endmodule